// File: doc/BRIEF.md
# UART Baud Tick Generator with Half-Step Prescaler

This block derives the timing strobes for a UART from the system clock. A 5-bit prescaler code selects a divide factor between 1 and 16 in steps of one half. An integer divisor stage follows it, and an oversampling counter comes last. The block produces a one-cycle sample tick at the oversampled rate and a one-cycle bit tick at the bit rate. A sample tick occurs once every `(code+1)/2 × (divisor+1)` system clocks on average. A bit tick occurs once every `oversample` sample ticks.

A prescaler code of zero is the power-down setting. In that setting every counter holds its value and no tick is issued. Software changes the rate by first writing code zero, then loading the new divisor, oversample rate and prescaler code. The first cycle in which the code is nonzero again restarts all counters from their initial values.

Top module: `baud_gen`

## Requirements
- R1: While the prescaler code sampled at a rising edge is zero, the next cycle has neither a sample tick nor a bit tick, and the counters hold their state.
- R2: For a fixed nonzero code c, prescaler events occur at an average interval of (c+1)/2 clocks. For even c the intervals alternate between floor and ceiling. Code 31 gives exactly 16 clocks and code 26 gives 13.5.
- R3: With divisor d, a sample tick is issued on every (d+1)-th prescaler event. The sample tick is high for one cycle per event.
- R4: With code c and divisor d running steadily, any window of (c+1)(d+1) consecutive cycles holds exactly two sample ticks.
- R5: A bit tick is issued together with every n-th sample tick, where n is the oversample rate. A rate of 0 is treated as 1. A bit tick never occurs without a sample tick.
- R6: The first rising edge that samples a nonzero code after a zero code restarts all counters and issues no tick. The first sample tick is then driven by the ceil((d+1)(c+1)/2)-th edge after that restart edge.
- R7: Changing the divisor or the oversample rate while running does not cut short the current count. The new value is used from the next reload of that counter.
- R8: While reset is low, both ticks are low and the block behaves as if powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| preSel | input | 5 | Prescaler code; 0 = power down, factor (code+1)/2 |
| baudDiv | input | DIV_W (8) | Divisor; the stage divides by baudDiv+1 |
| ovsRate | input | OVS_W (5) | Sample ticks per bit; 0 acts as 1 |
| sampleTick | output | 1 | One-cycle oversampling strobe |
| bitTick | output | 1 | One-cycle bit-rate strobe, coincident with a sample tick |

## Verification
The bench targets the half-step codes. A prescaler that rounds 13.5 down or up would put three ticks, or one, into a 27-cycle window instead of two. Code 2 produces back-to-back ticks, which catches an accumulator that drops its remainder. Restart latency after power-down is measured exactly, so a counter that resumes its stale state or takes an extra start cycle shows as an off-by-N first tick. A divisor change in mid-count must leave the current interval at the old length and stretch only the next one. A design that reloads immediately would shorten the current gap.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic start;    // first cycle with a nonzero code after power-down
    logic run;      // steady running cycle
    logic preTick;  // prescaler event in this cycle
  } baudStrb_t;

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_gen_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] preSel,
  output baudStrb_t        strb
);

  localparam int ACC_W = SEL_W + 2;

  logic [SEL_W-1:0] selQ;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic [ACC_W-1:0] thresh;
  logic             selOn;
  logic             wasOn;

  // Each clock is worth two half-units. One prescaler period is code+1 half-units.
  always_comb begin
    selOn        = (preSel != '0);
    wasOn        = (selQ != '0);
    thresh       = ACC_W'(preSel) + ACC_W'(1);
    accNext      = acc + ACC_W'(2);
    strb.start   = selOn && !wasOn;
    strb.run     = selOn && wasOn;
    strb.preTick = strb.run && (accNext >= thresh);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selQ <= '0;
      acc  <= '0;
    end else begin
      selQ <= preSel;
      if (strb.start) begin
        acc <= '0;
      end else if (strb.preTick) begin
        acc <= accNext - thresh;
      end else if (strb.run) begin
        acc <= accNext;
      end
    end
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.preTick && preSel >= SEL_W'(3)) |=> (!strb.preTick || preSel != $past(preSel)));

endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_gen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  baudStrb_t        strb,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic [OVS_W-1:0] ovsRate,
  output logic             sampleTick,
  output logic             bitTick
);

  logic [DIV_W-1:0] divCnt;
  logic [OVS_W-1:0] ovsCnt;
  logic [OVS_W-1:0] ovsLoad;

  always_comb begin
    ovsLoad = (ovsRate == '0) ? '0 : ovsRate - OVS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCnt     <= '0;
      ovsCnt     <= '0;
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end else begin
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
      if (strb.start) begin
        divCnt <= baudDiv;
        ovsCnt <= ovsLoad;
      end else if (strb.preTick) begin
        if (divCnt == '0) begin
          sampleTick <= 1'b1;
          divCnt     <= baudDiv;
          if (ovsCnt == '0) begin
            bitTick <= 1'b1;
            ovsCnt  <= ovsLoad;
          end else begin
            ovsCnt <= ovsCnt - OVS_W'(1);
          end
        end else begin
          divCnt <= divCnt - DIV_W'(1);
        end
      end
    end
  end

  // R5
  bit_with_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitTick |-> sampleTick);

  // R6
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.start |=> (!sampleTick && !bitTick));

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       preSel,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic [OVS_W-1:0] ovsRate,
  output logic             sampleTick,
  output logic             bitTick
);

  localparam int SEL_W = 5;

  baudStrb_t strb;

  baud_ctrl #(.SEL_W(SEL_W)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .preSel (preSel),
    .strb   (strb)
  );

  baud_dp #(.DIV_W(DIV_W), .OVS_W(OVS_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .baudDiv    (baudDiv),
    .ovsRate    (ovsRate),
    .sampleTick (sampleTick),
    .bitTick    (bitTick)
  );

  // R1
  power_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preSel == '0) |=> (!sampleTick && !bitTick));

  // R1
  tick_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleTick |-> ($past(preSel) != '0));

endmodule

// File: tb/baud_gen_tb_top.sv
`timescale 1ns/1ps
module baud_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] preSel;
  logic [7:0] baudDiv;
  logic [4:0] ovsRate;
  logic       sampleTick;
  logic       bitTick;

  int total = 0;
  int bad   = 0;
  bit checking = 1'b0;

  always #4 clk = ~clk;

  baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .preSel(preSel), .baudDiv(baudDiv),
    .ovsRate(ovsRate), .sampleTick(sampleTick), .bitTick(bitTick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model: counts half-units and events with plain integers.
  int  prevSel = 0, halves = 0, evInGroup = 0, groupLen = 1, smpInBit = 0, bitLen = 1;
  bit  expS = 0, expB = 0;
  always @(posedge clk) begin
    int c;
    c = preSel;
    expS = 0; expB = 0;
    if (!rst_n || c == 0) begin
      prevSel = 0;
    end else if (prevSel == 0) begin
      prevSel = c; halves = 0; evInGroup = 0; groupLen = baudDiv + 1;
      smpInBit = 0; bitLen = (ovsRate == 0) ? 1 : ovsRate;
    end else begin
      if ((halves + 2) / (c + 1) > halves / (c + 1)) begin
        evInGroup++;
        if (evInGroup == groupLen) begin
          expS = 1; evInGroup = 0; groupLen = baudDiv + 1;
          smpInBit++;
          if (smpInBit == bitLen) begin
            expB = 1; smpInBit = 0; bitLen = (ovsRate == 0) ? 1 : ovsRate;
          end
        end
      end
      halves += 2;
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (checking) begin
      check(sampleTick == expS, "R3 sample tick vs model", sampleTick, expS);
      check(bitTick == expB, "R5 bit tick vs model", bitTick, expB);
    end
  end

  task automatic countWin(input int n, output int s, output int b);
    s = 0; b = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sampleTick) s++;
      if (bitTick) b++;
    end
  endtask

  task automatic waitTick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sampleTick && n < 5000);
  endtask

  task automatic setRate(input int c, input int d, input int o);
    @(negedge clk);
    preSel = 0;
    repeat (3) @(negedge clk);
    baudDiv = d[7:0]; ovsRate = o[4:0]; preSel = c[4:0];
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s, b, n;
    rst_n = 0; preSel = 5'd31; baudDiv = 0; ovsRate = 1;
    repeat (4) @(negedge clk);
    check(sampleTick == 0 && bitTick == 0, "R8 reset outputs low", sampleTick, 0);
    preSel = 0; rst_n = 1; checking = 1;

    countWin(30, s, b);
    check(s == 0, "R1 idle at code zero", s, 0);

    // Integer factor 16
    setRate(31, 0, 1);
    countWin(40, s, b);
    countWin(160, s, b);
    check(s == 10, "R2 code 31 gives 16 clocks", s, 10);

    // Half-step factor 13.5 with restart latency
    setRate(26, 1, 2);
    waitTick(n);
    check(n == 28, "R6 first tick latency", n, 28);
    countWin(270, s, b);
    check(s == 10, "R4 two ticks per (c+1)(d+1)", s, 10);
    check(b == 5, "R5 bit every 2 samples", b, 5);

    setRate(26, 0, 4);
    countWin(100, s, b);
    countWin(540, s, b);
    check(s == 40, "R2 code 26 gives 13.5 clocks", s, 40);
    check(b == 10, "R5 bit every 4 samples", b, 10);

    // Freeze while powered down
    @(negedge clk); preSel = 0;
    countWin(50, s, b);
    check(s == 0 && b == 0, "R1 frozen at code zero", s, 0);

    // Factor 1.5: back-to-back ticks
    setRate(2, 0, 3);
    countWin(30, s, b);
    countWin(30, s, b);
    check(s == 20, "R2 code 2 gives 1.5 clocks", s, 20);

    // Oversample 0 acts as 1
    setRate(1, 3, 0);
    countWin(20, s, b);
    countWin(40, s, b);
    check(s == 10, "R3 divide by d+1", s, 10);
    check(b == 10, "R5 oversample zero as one", b, 10);

    // Divisor change mid-count
    waitTick(n);
    baudDiv = 7;
    waitTick(n);
    check(n == 4, "R7 current gap keeps old divisor", n, 4);
    waitTick(n);
    check(n == 8, "R7 next gap uses new divisor", n, 8);
    ovsRate = 3;
    countWin(200, s, b);

    checking = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule